// File: doc/BRIEF.md
# Bus Master Retry Termination Controller

This block runs single transfers on an external bus on behalf of a core. The core hands over a transfer through a valid/ready request port. The block wins the bus, pulses a transfer-start strobe, and then waits for one of three ends: a normal acknowledge, an error acknowledge, or a retry request. A normal acknowledge returns the read data. An error acknowledge returns an error flag instead of a normal completion. A retry sends nothing back to the core. The block gives the bus up for one cycle, arbitrates again, and reissues the same transfer from a held copy.

A static strap selects how bus ownership is handled. With the internal arbiter, the block drives the grant line, so that a second master can take the bus after a retry. With an external arbiter, the block drives a request line and waits for an incoming grant. A built-in bus monitor ends a transfer with an error when no acknowledge arrives within `MON_CYCLES` clocks of waiting. The error acknowledge input is a vector of active-low sources that are OR-combined.

Top module: `bus_retry_master`

## Requirements
- R1: While reset is asserted, `bus_busy_n`, `bus_req_n` and `bus_grant_n` are high, `bus_ts` and `rsp_valid` are low, and `req_ready` is high.
- R2: A transfer is accepted on a clock where `req_valid` and `req_ready` are both high. In internal-arbiter mode with no competing master, `bus_ts` is high and `bus_busy_n` is low two cycles after acceptance. The next cycle is the first wait cycle. When `bus_ta_n` is sampled low in a wait cycle, with no error or retry, the next cycle shows a one-cycle `rsp_valid` pulse with `rsp_err` low and `rsp_rdata` equal to `bus_rdata` from the acknowledge cycle. In that same cycle `bus_busy_n` returns high.
- R3: If any bit of `bus_tea_n` is sampled low in a wait cycle, the transfer ends with `rsp_valid` and `rsp_err` high, even if `bus_ta_n` is low in the same cycle.
- R4: An error acknowledge and a retry sampled in the same wait cycle give an error response. The transfer is not replayed, and the grant stays high.
- R5: If a transfer sees no acknowledge, error or retry for `MON_CYCLES` wait cycles, it ends with an error response one cycle later. An acknowledge sampled in the last of those cycles still completes normally.
- R6: The error acknowledge is sampled only in wait cycles. A low level that stays on after an error, through the acceptance, arbitration and start of the next transfer, does not affect that transfer.
- R7: A retry sampled low in a wait cycle produces no response. The replayed transfer carries the same address, attributes, direction and write data.
- R8: In internal-arbiter mode, the cycle after a retry has `bus_busy_n` high and `bus_grant_n` low. The following cycle arbitrates with the grant high. With no competing request, `bus_ts` follows one cycle after that.
- R9: In internal-arbiter mode, if `peer_req_n` is low during the release or arbitration cycle, `bus_grant_n` stays low and no transfer starts. Once `peer_req_n` goes high, the block arbitrates again and starts two cycles later.
- R10: In external-arbiter mode, `bus_req_n` is low from arbitration to the end of the transfer. The start waits until `arb_grant_n` is sampled low. The cycle after a retry has both `bus_req_n` and `bus_busy_n` high, and the cycle after that asserts `bus_req_n` again.
- R11: `req_ready` is low while a transfer is in progress, and a request presented then is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arb_int | input | 1 | Strap: 1 selects the internal arbiter, 0 selects an external arbiter |
| req_valid | input | 1 | Core presents a transfer |
| req_ready | output | 1 | Block can take a transfer (idle) |
| req_addr | input | AW | Transfer address |
| req_attr | input | ATW | Transfer attributes |
| req_we | input | 1 | 1 = write |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion ended with an error |
| rsp_rdata | output | DW | Read data of a normal completion |
| bus_addr | output | AW | Held address on the bus |
| bus_attr | output | ATW | Held attributes |
| bus_we | output | 1 | Held direction |
| bus_wdata | output | DW | Held write data |
| bus_rdata | input | DW | Read data from the slave |
| bus_ts | output | 1 | Transfer-start strobe |
| bus_ta_n | input | 1 | Transfer acknowledge, active low |
| bus_tea_n | input | NTEA | Error acknowledge sources, active low, OR-combined |
| bus_retry_n | input | 1 | Retry request, active low |
| bus_busy_n | output | 1 | Bus busy, active low |
| bus_req_n | output | 1 | Bus request to an external arbiter, active low |
| bus_grant_n | output | 1 | Bus grant to another master (internal arbiter), active low |
| peer_req_n | input | 1 | Other master requests the bus (internal arbiter), active low |
| arb_grant_n | input | 1 | Grant from an external arbiter, active low |

## Verification
The bench targets the same-cycle collisions. The first is error with acknowledge: a design with the priority reversed would report success. The second is error with retry: a design that favoured retry would replay a transfer that should have failed. The bus-monitor limit is tested on both sides of the boundary: an off-by-one counter either cuts off an acknowledge that arrived in the last allowed cycle or lets one extra cycle pass. A lingering error level across the next transfer's start catches a design that samples the error input outside the wait phase. The retry paths in both arbiter modes, with and without a competing master, catch a wrong release cycle, a missing grant, and a replay with altered address or data.

// File: rtl/brm_pkg.sv
package brm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_START,
        ST_WAIT,
        ST_REL,
        ST_EXT
    } brm_state_e;

    typedef enum logic [1:0] {
        TM_NONE,
        TM_ACK,
        TM_ERR,
        TM_RETRY
    } brm_term_e;
endpackage

// File: rtl/brm_term.sv
module brm_term
    import brm_pkg::*;
#(
    parameter int NTEA = 2
) (
    input  logic            in_wait,
    input  logic [NTEA-1:0] tea_n,
    input  logic            retry_n,
    input  logic            ta_n,
    input  logic            expired,
    output brm_term_e       term
);
    logic tea_any;
    assign tea_any = ~&tea_n;

    // priority: error > retry > acknowledge > monitor timeout
    always_comb begin
        term = TM_NONE;
        if (in_wait) begin
            if (tea_any)       term = TM_ERR;
            else if (!retry_n) term = TM_RETRY;
            else if (!ta_n)    term = TM_ACK;
            else if (expired)  term = TM_ERR;
        end
    end
endmodule

// File: rtl/brm_busmon.sv
module brm_busmon #(
    parameter int MON_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic expired
);
    generate
        if (MON_CYCLES == 0) begin : g_off
            assign expired = 1'b0;
        end else begin : g_on
            localparam int CW = (MON_CYCLES < 2) ? 1 : $clog2(MON_CYCLES);
            localparam logic [CW-1:0] LAST = CW'(MON_CYCLES - 1);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (clr)
                    cnt_d = '0;
                else if (adv && cnt_q != LAST)
                    cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign expired = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/brm_hold.sv
module brm_hold #(
    parameter int AW  = 32,
    parameter int ATW = 4,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [AW-1:0]  in_addr,
    input  logic [ATW-1:0] in_attr,
    input  logic           in_we,
    input  logic [DW-1:0]  in_wdata,
    output logic [AW-1:0]  out_addr,
    output logic [ATW-1:0] out_attr,
    output logic           out_we,
    output logic [DW-1:0]  out_wdata
);
    typedef struct packed {
        logic [AW-1:0]  addr;
        logic [ATW-1:0] attr;
        logic           we;
        logic [DW-1:0]  wdata;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (load) begin
            h_d.addr  = in_addr;
            h_d.attr  = in_attr;
            h_d.we    = in_we;
            h_d.wdata = in_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign out_addr  = h_q.addr;
    assign out_attr  = h_q.attr;
    assign out_we    = h_q.we;
    assign out_wdata = h_q.wdata;
endmodule

// File: rtl/bus_retry_master.sv
module bus_retry_master
    import brm_pkg::*;
#(
    parameter int AW         = 32,
    parameter int ATW        = 4,
    parameter int DW         = 32,
    parameter int NTEA       = 2,
    parameter int MON_CYCLES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arb_int,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [AW-1:0]   req_addr,
    input  logic [ATW-1:0]  req_attr,
    input  logic            req_we,
    input  logic [DW-1:0]   req_wdata,
    output logic            rsp_valid,
    output logic            rsp_err,
    output logic [DW-1:0]   rsp_rdata,
    output logic [AW-1:0]   bus_addr,
    output logic [ATW-1:0]  bus_attr,
    output logic            bus_we,
    output logic [DW-1:0]   bus_wdata,
    input  logic [DW-1:0]   bus_rdata,
    output logic            bus_ts,
    input  logic            bus_ta_n,
    input  logic [NTEA-1:0] bus_tea_n,
    input  logic            bus_retry_n,
    output logic            bus_busy_n,
    output logic            bus_req_n,
    output logic            bus_grant_n,
    input  logic            peer_req_n,
    input  logic            arb_grant_n
);
    typedef struct packed {
        brm_state_e    state;
        logic          rsp_valid;
        logic          rsp_err;
        logic [DW-1:0] rsp_rdata;
    } ctl_t;

    ctl_t       r_d, r_q;
    brm_term_e  term;
    brm_state_e st_q;
    logic       mon_expired;
    logic       in_wait;
    logic       hold_load;
    logic       mon_clr;
    logic       mon_adv;

    assign st_q    = r_q.state;
    assign in_wait = (r_q.state == ST_WAIT);
    assign mon_clr = (r_q.state == ST_START);
    assign mon_adv = in_wait && (term == TM_NONE);

    brm_term #(.NTEA(NTEA)) u_term (
        .in_wait (in_wait),
        .tea_n   (bus_tea_n),
        .retry_n (bus_retry_n),
        .ta_n    (bus_ta_n),
        .expired (mon_expired),
        .term    (term)
    );

    brm_busmon #(.MON_CYCLES(MON_CYCLES)) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mon_clr),
        .adv     (mon_adv),
        .expired (mon_expired)
    );

    brm_hold #(.AW(AW), .ATW(ATW), .DW(DW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (hold_load),
        .in_addr   (req_addr),
        .in_attr   (req_attr),
        .in_we     (req_we),
        .in_wdata  (req_wdata),
        .out_addr  (bus_addr),
        .out_attr  (bus_attr),
        .out_we    (bus_we),
        .out_wdata (bus_wdata)
    );

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        hold_load     = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    hold_load = 1'b1;
                    r_d.state = ST_ARB;
                end
            end
            ST_ARB: begin
                if (arb_int) begin
                    if (!peer_req_n) r_d.state = ST_EXT;
                    else             r_d.state = ST_START;
                end else if (!arb_grant_n) begin
                    r_d.state = ST_START;
                end
            end
            ST_START: r_d.state = ST_WAIT;
            ST_WAIT: begin
                case (term)
                    TM_ERR: begin
                        r_d.rsp_valid = 1'b1;
                        r_d.rsp_err   = 1'b1;
                        r_d.state     = ST_IDLE;
                    end
                    TM_ACK: begin
                        r_d.rsp_valid = 1'b1;
                        r_d.rsp_err   = 1'b0;
                        r_d.rsp_rdata = bus_rdata;
                        r_d.state     = ST_IDLE;
                    end
                    TM_RETRY: r_d.state = ST_REL;
                    default:  r_d.state = ST_WAIT;
                endcase
            end
            ST_REL: r_d.state = ST_ARB;
            ST_EXT: begin
                if (peer_req_n) r_d.state = ST_ARB;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= ST_IDLE;
            r_q.rsp_valid <= 1'b0;
            r_q.rsp_err   <= 1'b0;
            r_q.rsp_rdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready   = (r_q.state == ST_IDLE);
    assign rsp_valid   = r_q.rsp_valid;
    assign rsp_err     = r_q.rsp_err;
    assign rsp_rdata   = r_q.rsp_rdata;
    assign bus_ts      = (r_q.state == ST_START);
    assign bus_busy_n  = !((r_q.state == ST_START) || in_wait);
    assign bus_req_n   = arb_int || !((r_q.state == ST_ARB) ||
                                      (r_q.state == ST_START) || in_wait);
    assign bus_grant_n = !(arb_int && ((r_q.state == ST_REL) ||
                                       (r_q.state == ST_EXT) ||
                                       ((r_q.state == ST_ARB) && !peer_req_n)));
endmodule

// File: rtl/brm_chk.sv
module brm_chk
    import brm_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int NTEA = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            arb_int,
    input brm_state_e      st,
    input logic [NTEA-1:0] bus_tea_n,
    input logic            bus_retry_n,
    input logic            bus_ta_n,
    input logic            mon_expired,
    input logic            rsp_valid,
    input logic            rsp_err,
    input logic            bus_busy_n,
    input logic            bus_req_n,
    input logic            bus_grant_n,
    input logic [AW-1:0]   bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic            req_ready
);
    logic waiting;
    logic tea_low;
    assign waiting = (st == ST_WAIT);
    assign tea_low = ~&bus_tea_n;

    AST_ACK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        waiting && !tea_low && bus_retry_n && !bus_ta_n |=> rsp_valid && !rsp_err); // R2
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R2
    AST_ERR_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        waiting && tea_low |=> rsp_valid && rsp_err); // R3
    AST_ERR_BEATS_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        waiting && tea_low && !bus_retry_n |=> rsp_valid && bus_grant_n && bus_busy_n); // R4
    AST_MON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        waiting && mon_expired && !tea_low && bus_retry_n && bus_ta_n |=> rsp_valid && rsp_err); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready && !$past(req_ready) |-> $stable(bus_addr) && $stable(bus_wdata)); // R7
    AST_RETRY_INT_REL: assert property (@(posedge clk) disable iff (!rst_n)
        waiting && !tea_low && !bus_retry_n && arb_int |=> !rsp_valid && bus_busy_n && !bus_grant_n); // R8
    AST_RETRY_EXT_REL: assert property (@(posedge clk) disable iff (!rst_n)
        waiting && !tea_low && !bus_retry_n && !arb_int |=> !rsp_valid && bus_busy_n && bus_req_n); // R10
endmodule

bind bus_retry_master brm_chk #(.AW(AW), .DW(DW), .NTEA(NTEA)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .arb_int     (arb_int),
    .st          (st_q),
    .bus_tea_n   (bus_tea_n),
    .bus_retry_n (bus_retry_n),
    .bus_ta_n    (bus_ta_n),
    .mon_expired (mon_expired),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .bus_busy_n  (bus_busy_n),
    .bus_req_n   (bus_req_n),
    .bus_grant_n (bus_grant_n),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .req_ready   (req_ready)
);

// File: tb/sim_bus_retry_master.sv
`timescale 1ns/1ps
module sim_bus_retry_master;
    localparam int AW = 32, ATW = 4, DW = 32, NTEA = 2, MONC = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arb_int = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [ATW-1:0] req_attr = '0;
    logic req_we = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic rsp_valid, rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] bus_addr;
    logic [ATW-1:0] bus_attr;
    logic bus_we;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic bus_ts;
    logic bus_ta_n = 1'b1;
    logic [NTEA-1:0] bus_tea_n = '1;
    logic bus_retry_n = 1'b1;
    logic bus_busy_n, bus_req_n, bus_grant_n;
    logic peer_req_n = 1'b1;
    logic arb_grant_n = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bus_retry_master #(.AW(AW), .ATW(ATW), .DW(DW), .NTEA(NTEA), .MON_CYCLES(MONC)) u0 (
        .clk(clk), .rst_n(rst_n), .arb_int(arb_int),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_attr(req_attr), .req_we(req_we), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_attr(bus_attr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ts(bus_ts),
        .bus_ta_n(bus_ta_n), .bus_tea_n(bus_tea_n), .bus_retry_n(bus_retry_n),
        .bus_busy_n(bus_busy_n), .bus_req_n(bus_req_n), .bus_grant_n(bus_grant_n),
        .peer_req_n(peer_req_n), .arb_grant_n(arb_grant_n)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic issue(input logic [AW-1:0] a, input logic [ATW-1:0] at,
                         input logic we, input logic [DW-1:0] wd);
        check("R11 ready when idle", req_ready, 1);
        req_valid = 1'b1; req_addr = a; req_attr = at; req_we = we; req_wdata = wd;
        step();
        req_valid = 1'b0;
    endtask

    task automatic wait_ts(output int n);
        n = 0;
        while (!bus_ts && n < 100) begin
            step();
            n++;
        end
    endtask

    task automatic t_normal();
        int n;
        issue(32'h1000_0040, 4'h5, 1'b0, 32'h0);
        check("R11 ready low while busy", req_ready, 0);
        req_valid = 1'b1; req_addr = 32'hDEAD_0000;
        wait_ts(n);
        req_valid = 1'b0;
        check("R2 start latency", n, 1);
        check("R2 busy at start", bus_busy_n, 0);
        check("R11 address not replaced", bus_addr, 32'h1000_0040);
        step();
        bus_ta_n = 1'b0; bus_rdata = 32'hCAFE_1234;
        step();
        bus_ta_n = 1'b1;
        check("R2 rsp_valid", rsp_valid, 1);
        check("R2 rsp_err", rsp_err, 0);
        check("R2 rdata", rsp_rdata, 32'hCAFE_1234);
        check("R2 bus released", bus_busy_n, 1);
        step();
        check("R2 single pulse", rsp_valid, 0);
        check("R11 stray request not started", bus_ts, 0);
    endtask

    task automatic t_err_ta();
        int n;
        issue(32'h2000_0000, 4'h1, 1'b0, 32'h0);
        wait_ts(n);
        step();
        bus_tea_n = 2'b01; bus_ta_n = 1'b0;
        step();
        bus_tea_n = '1; bus_ta_n = 1'b1;
        check("R3 error with ack valid", rsp_valid, 1);
        check("R3 error with ack err", rsp_err, 1);
        step();
    endtask

    task automatic t_err_retry();
        int n;
        issue(32'h3000_0000, 4'h2, 1'b1, 32'h5555);
        wait_ts(n);
        step();
        bus_tea_n = 2'b10; bus_retry_n = 1'b0;
        step();
        bus_tea_n = '1; bus_retry_n = 1'b1;
        check("R4 error over retry valid", rsp_valid, 1);
        check("R4 error over retry err", rsp_err, 1);
        check("R4 no grant", bus_grant_n, 1);
        for (int k = 0; k < 3; k++) begin
            step();
            check("R4 no replay", bus_ts, 0);
        end
    endtask

    task automatic t_monitor();
        int n;
        issue(32'h4000_0000, 4'h3, 1'b0, 32'h0);
        wait_ts(n);
        step();
        for (int k = 0; k < MONC; k++) begin
            check("R5 no early timeout", rsp_valid, 0);
            step();
        end
        check("R5 timeout valid", rsp_valid, 1);
        check("R5 timeout err", rsp_err, 1);
        step();
        issue(32'h4000_0004, 4'h3, 1'b0, 32'h0);
        wait_ts(n);
        step();
        repeat (MONC - 1) step();
        bus_ta_n = 1'b0; bus_rdata = 32'h0000_BEEF;
        step();
        bus_ta_n = 1'b1;
        check("R5 ack in last cycle valid", rsp_valid, 1);
        check("R5 ack in last cycle err", rsp_err, 0);
        step();
    endtask

    task automatic t_tea_ignored();
        int n;
        issue(32'h5000_0000, 4'h4, 1'b0, 32'h0);
        wait_ts(n);
        step();
        bus_tea_n = 2'b10;
        step();
        check("R6 first ends in error", rsp_err, 1);
        issue(32'h5000_0008, 4'h4, 1'b0, 32'h0);
        wait_ts(n);
        check("R6 start unaffected", n, 1);
        bus_tea_n = '1;
        step();
        bus_ta_n = 1'b0; bus_rdata = 32'h0000_0777;
        step();
        bus_ta_n = 1'b1;
        check("R6 next transfer valid", rsp_valid, 1);
        check("R6 next transfer ok", rsp_err, 0);
        step();
    endtask

    task automatic t_retry_int();
        int n;
        issue(32'h6000_0010, 4'hA, 1'b1, 32'h1357_9BDF);
        wait_ts(n);
        step();
        bus_retry_n = 1'b0;
        step();
        bus_retry_n = 1'b1;
        check("R7 no response on retry", rsp_valid, 0);
        check("R8 busy released", bus_busy_n, 1);
        check("R8 grant asserted", bus_grant_n, 0);
        step();
        check("R8 grant back high", bus_grant_n, 1);
        check("R8 no start during arbitration", bus_ts, 0);
        step();
        check("R8 replay starts", bus_ts, 1);
        check("R7 same addr", bus_addr, 32'h6000_0010);
        check("R7 same attr", bus_attr, 4'hA);
        check("R7 same dir", bus_we, 1);
        check("R7 same wdata", bus_wdata, 32'h1357_9BDF);
        step();
        bus_ta_n = 1'b0;
        step();
        bus_ta_n = 1'b1;
        check("R7 replay completes", rsp_valid, 1);
        step();
    endtask

    task automatic t_peer();
        int n;
        issue(32'h7000_0020, 4'h6, 1'b0, 32'h0);
        wait_ts(n);
        step();
        bus_retry_n = 1'b0;
        step();
        bus_retry_n = 1'b1;
        peer_req_n = 1'b0;
        step();
        check("R9 grant held in arbitration", bus_grant_n, 0);
        for (int k = 0; k < 3; k++) begin
            step();
            check("R9 no start while peer owns", bus_ts, 0);
            check("R9 grant kept", bus_grant_n, 0);
        end
        peer_req_n = 1'b1;
        wait_ts(n);
        check("R9 restart latency", n, 2);
        check("R9 replay addr", bus_addr, 32'h7000_0020);
        step();
        bus_ta_n = 1'b0;
        step();
        bus_ta_n = 1'b1;
        check("R9 completes", rsp_valid, 1);
        step();
    endtask

    task automatic t_ext();
        arb_int = 1'b0;
        issue(32'h8000_0030, 4'h9, 1'b1, 32'h2468_ACE0);
        check("R10 request asserted", bus_req_n, 0);
        check("R10 grant unused", bus_grant_n, 1);
        step();
        check("R10 waits for grant", bus_ts, 0);
        step();
        check("R10 still waits", bus_ts, 0);
        arb_grant_n = 1'b0;
        step();
        check("R10 start on grant", bus_ts, 1);
        check("R10 request held", bus_req_n, 0);
        step();
        bus_retry_n = 1'b0;
        step();
        bus_retry_n = 1'b1;
        check("R10 request released", bus_req_n, 1);
        check("R10 busy released", bus_busy_n, 1);
        check("R10 no response", rsp_valid, 0);
        step();
        check("R10 request again", bus_req_n, 0);
        step();
        check("R10 replay start", bus_ts, 1);
        check("R10 replay wdata", bus_wdata, 32'h2468_ACE0);
        step();
        bus_ta_n = 1'b0;
        step();
        bus_ta_n = 1'b1;
        arb_grant_n = 1'b1;
        check("R10 completes", rsp_valid, 1);
        step();
        check("R10 request dropped in idle", bus_req_n, 1);
        arb_int = 1'b1;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) step();
        check("R1 busy idle", bus_busy_n, 1);
        check("R1 req idle", bus_req_n, 1);
        check("R1 grant idle", bus_grant_n, 1);
        check("R1 no rsp", rsp_valid, 0);
        check("R1 no start", bus_ts, 0);
        check("R1 ready", req_ready, 1);
        rst_n = 1'b1;
        step();
        t_normal();
        t_err_ta();
        t_err_retry();
        t_monitor();
        t_tea_ignored();
        t_retry_int();
        t_peer();
        t_ext();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
    end
endmodule